// File: doc/BRIEF.md
# Phase-Lock Data Carrier Detector

This block tells a packet controller whether a decodable data carrier is on the channel. It does not judge by signal level. It runs a digital phase-locked loop on the NRZI receive stream from the demodulator. The loop runs on an oversampled clock of 16 or 32 ticks per bit. On noise, data edges land at random phases, so the loop keeps correcting itself. On a real carrier, edges arrive on the bit grid and the corrections stop.

A retriggerable quiet timer restarts on every loop correction. It declares a raw detect once a full timeout passes with no correction. A second timer keeps the indication up for a hang period after the raw detect drops. This carries the detect through short fades and collisions. The result is also gated by the modem's own level-based carrier line. That line's polarity is selectable by a static input.

The detect result is driven in both polarities. The recovered NRZI-decoded bits come out with a one-tick strobe. The loop's correction pulse is also exposed for observation.

Top module: `dcd_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dcd_hi` is 0, `dcd_lo_n` is 1 and `pll_update` is 0.
- R2: A level change on `rx_nrzi` that reaches the loop outside ±`LOCK_WIN` ticks of phase 0 produces a one-cycle `pll_update` pulse. The pulse is visible in the cycle after the third rising clock edge following the input change. The phase is then realigned so that phase 0 lies on that edge.
- R3: When data edges fall on the bit grid (multiples of `OSR` ticks), no `pll_update` occurs once the loop is aligned. `rx_bit_vld` pulses exactly once every `OSR` ticks. `rx_bit` is 1 when the line level did not change since the previous sample, and 0 when it did (NRZI decode).
- R4: After `QUIET_TICKS` consecutive clock edges with no loop correction, the raw detect becomes true. `dcd_hi` rises one edge later. Coming out of reset with a quiet line, this means `dcd_hi` is 0 after `QUIET_TICKS` edges and 1 after `QUIET_TICKS`+1 edges.
- R5: While corrections arrive more often than every `QUIET_TICKS` ticks (noise), `dcd_hi` stays 0 once any hang period has expired.
- R6: When the raw detect falls, `dcd_hi` stays 1 for at least `HANG_TICKS` further ticks. If corrections keep coming, it then drops within a few ticks. A short burst of corrections shorter than the hang does not interrupt `dcd_hi`.
- R7: `dcd_hi` is 1 only while the polarity-corrected modem carrier is active. With `cd_active_low` 0, `modem_cd`=1 means active. With `cd_active_low` 1, `modem_cd`=0 means active. A change on either input reaches `dcd_hi` on the third rising edge after it.
- R8: `dcd_lo_n` is always the complement of `dcd_hi`.
- R9: Both timers saturate. A quiet line held far longer than `QUIET_TICKS` keeps `dcd_hi` at 1 with no drop-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_os | input | 1 | Oversampled clock, `OSR` ticks per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_nrzi | input | 1 | NRZI receive data from the demodulator (asynchronous) |
| modem_cd | input | 1 | Level-based carrier line from the modem (asynchronous) |
| cd_active_low | input | 1 | 1 when `modem_cd` is active-low, 0 when active-high |
| dcd_hi | output | 1 | Carrier detect, active high |
| dcd_lo_n | output | 1 | Carrier detect, active low |
| pll_update | output | 1 | One-cycle pulse on each loop phase correction |
| rx_bit | output | 1 | NRZI-decoded recovered bit |
| rx_bit_vld | output | 1 | One-cycle strobe marking `rx_bit` valid |

## Verification
Each result has its own latency. A data edge shows up as a correction pulse after three rising edges: two synchronizer flops plus the pulse register. A carrier-line change reaches `dcd_hi` after three edges. The quiet timeout shows on `dcd_hi` one edge after the timer count reaches its limit. The hang release comes four edges after the correction that ends the quiet spell, plus the hang length.

The bench drives inputs at falling edges and counts rising edges before sampling at the next falling edge. Where the free-running loop phase is unknown, it brackets the event between a bound it cannot yet have reached and one it must already have passed. It does not sample a single guessed cycle.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // True when a data edge seen at loop phase p is close enough to the
  // bit boundary (phase 0) to need no correction.
  function automatic logic phase_in_window(int unsigned p, int unsigned win,
                                           int unsigned osr);
    return (p <= win) || (p + win >= osr);
  endfunction

  // NRZI decode: no level change across a bit cell is a one.
  function automatic logic nrzi_bit(logic now_lvl, logic prev_lvl);
    return now_lvl == prev_lvl;
  endfunction

  // Next value of a saturating up-counter.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Next value of a down-counter that stops at zero.
  function automatic int unsigned sat_dec(int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcd_dpll.sv
module dcd_dpll
  import dcd_pkg::*;
#(
  parameter int unsigned OSR      = 16,
  parameter int unsigned LOCK_WIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic upd_o,
  output logic bit_o,
  output logic bit_vld_o
);
  localparam int unsigned PW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [PW-1:0] LAST_PH   = PW'(OSR - 1);
  localparam logic [PW-1:0] SAMPLE_PH = PW'(OSR / 2);
  localparam logic [PW-1:0] ALIGN_PH  = PW'(1);

  logic [PW-1:0] phase_q;
  logic          prev_q;
  logic          ref_q;
  logic          upd_q;
  logic          bit_q;
  logic          vld_q;
  logic          edge_w;
  logic          misalign_w;
  logic          sample_w;

  assign edge_w     = rxd ^ prev_q;
  assign misalign_w = edge_w && !phase_in_window(32'(phase_q), LOCK_WIN, OSR);
  assign sample_w   = (phase_q == SAMPLE_PH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      prev_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      prev_q <= rxd;
      upd_q  <= misalign_w;
      if (misalign_w)             phase_q <= ALIGN_PH;
      else if (phase_q == LAST_PH) phase_q <= '0;
      else                         phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= sample_w;
      if (sample_w) begin
        bit_q <= nrzi_bit(rxd, ref_q);
        ref_q <= rxd;
      end
    end
  end

  assign upd_o     = upd_q;
  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
endmodule

// File: rtl/dcd_quiet_timer.sv
module dcd_quiet_timer
  import dcd_pkg::*;
#(
  parameter int unsigned LIMIT = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= CW'(sat_inc(32'(cnt_q), LIMIT));
  end

  assign expired = (cnt_q >= LIM);
endmodule

// File: rtl/dcd_hang_timer.sv
module dcd_hang_timer
  import dcd_pkg::*;
#(
  parameter int unsigned LEN = 768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic hold
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (trig) cnt_q <= LOAD;
    else           cnt_q <= CW'(sat_dec(32'(cnt_q)));
  end

  assign hold = trig || (cnt_q != '0);
endmodule

// File: rtl/dcd_top.sv
module dcd_top #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned LOCK_WIN    = 1,
  parameter int unsigned QUIET_TICKS = 160,
  parameter int unsigned HANG_TICKS  = 768
) (
  input  logic clk_os,
  input  logic rst_n,
  input  logic rx_nrzi,
  input  logic modem_cd,
  input  logic cd_active_low,
  output logic dcd_hi,
  output logic dcd_lo_n,
  output logic pll_update,
  output logic rx_bit,
  output logic rx_bit_vld
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] async_in;
  logic [NSYNC-1:0] sync_out;
  logic rxd_s;
  logic cd_s;
  logic pol_s;
  logic cd_ok;
  logic raw_det;
  logic hold_det;
  logic det_w;
  logic dcd_hi_q;
  logic dcd_lo_q;

  assign async_in = {cd_active_low, modem_cd, rx_nrzi};

  dcd_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk(clk_os), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );

  assign rxd_s = sync_out[0];
  assign cd_s  = sync_out[1];
  assign pol_s = sync_out[2];
  assign cd_ok = pol_s ? ~cd_s : cd_s;

  dcd_dpll #(.OSR(OSR), .LOCK_WIN(LOCK_WIN)) u_dpll (
    .clk(clk_os), .rst_n(rst_n), .rxd(rxd_s),
    .upd_o(pll_update), .bit_o(rx_bit), .bit_vld_o(rx_bit_vld)
  );

  dcd_quiet_timer #(.LIMIT(QUIET_TICKS)) u_quiet (
    .clk(clk_os), .rst_n(rst_n), .restart(pll_update), .expired(raw_det)
  );

  dcd_hang_timer #(.LEN(HANG_TICKS)) u_hang (
    .clk(clk_os), .rst_n(rst_n), .trig(raw_det), .hold(hold_det)
  );

  assign det_w = hold_det && cd_ok;

  always_ff @(posedge clk_os) begin
    if (!rst_n) begin
      dcd_hi_q <= 1'b0;
      dcd_lo_q <= 1'b1;
    end else begin
      dcd_hi_q <= det_w;
      dcd_lo_q <= ~det_w;
    end
  end

  assign dcd_hi   = dcd_hi_q;
  assign dcd_lo_n = dcd_lo_q;
endmodule

// File: rtl/dcd_top_chk.sv
module dcd_top_chk (
  input logic clk_os,
  input logic rst_n,
  input logic dcd_hi,
  input logic dcd_lo_n,
  input logic pll_update,
  input logic raw_det,
  input logic hold_det,
  input logic cd_ok,
  input logic rx_bit_vld
);
  // R8
  polarity_pair_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
    dcd_lo_n == !dcd_hi);

  // R4
  restart_clears_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
    pll_update |=> !raw_det);

  // R6
  hang_covers_fall_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
    $fell(raw_det) |-> hold_det);

  // R7
  carrier_gate_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
    dcd_hi |-> $past(cd_ok));

  // R3
  single_strobe_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
    rx_bit_vld |=> !rx_bit_vld);
endmodule

bind dcd_top dcd_top_chk u_chk (
  .clk_os(clk_os), .rst_n(rst_n), .dcd_hi(dcd_hi), .dcd_lo_n(dcd_lo_n),
  .pll_update(pll_update), .raw_det(raw_det), .hold_det(hold_det),
  .cd_ok(cd_ok), .rx_bit_vld(rx_bit_vld)
);

// File: tb/dcd_top_bench.sv
module dcd_top_bench;
  localparam int unsigned OSR  = 16;
  localparam int unsigned WIN  = 1;
  localparam int unsigned Q    = 64;
  localparam int unsigned HANG = 100;

  logic clk_os = 1'b0;
  logic rst_n  = 1'b0;
  logic rx_nrzi = 1'b0;
  logic modem_cd = 1'b1;
  logic cd_active_low = 1'b0;
  logic dcd_hi, dcd_lo_n, pll_update, rx_bit, rx_bit_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk_os = ~clk_os;

  dcd_top #(.OSR(OSR), .LOCK_WIN(WIN), .QUIET_TICKS(Q), .HANG_TICKS(HANG)) u_dcd_top (
    .clk_os(clk_os), .rst_n(rst_n), .rx_nrzi(rx_nrzi), .modem_cd(modem_cd),
    .cd_active_low(cd_active_low), .dcd_hi(dcd_hi), .dcd_lo_n(dcd_lo_n),
    .pll_update(pll_update), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_os);
    @(negedge clk_os);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rx_nrzi = 1'b0; modem_cd = 1'b1; cd_active_low = 1'b0;
    step(5);
    check(dcd_hi == 1'b0, "R1 dcd_hi in reset", dcd_hi, 0);
    check(dcd_lo_n == 1'b1, "R1 dcd_lo_n in reset", dcd_lo_n, 1);
    check(pll_update == 1'b0, "R1 pll_update in reset", pll_update, 0);
    rst_n = 1'b1;
    step(1);
    check(dcd_hi == 1'b0, "R1 dcd_hi after release", dcd_hi, 0);
    step(Q - 1);
    check(dcd_hi == 1'b0, "R4 not yet at QUIET_TICKS", dcd_hi, 0);
    step(1);
    check(dcd_hi == 1'b1, "R4 asserted at QUIET_TICKS+1", dcd_hi, 1);
    check(dcd_lo_n == 1'b0, "R8 low output", dcd_lo_n, 0);
  endtask

  task automatic t_saturate;
    int ups = 0;
    int lows = 0;
    for (int i = 0; i < 3 * int'(Q); i++) begin
      step(1);
      if (pll_update) ups++;
      if (!dcd_hi) lows++;
    end
    check(lows == 0, "R9 no drop on long quiet", lows, 0);
    check(ups == 0, "R9 no correction on quiet", ups, 0);
  endtask

  task automatic t_update_latency;
    int lows = 0;
    rx_nrzi = ~rx_nrzi;
    step(8);
    rx_nrzi = ~rx_nrzi;
    step(2);
    check(pll_update == 1'b0, "R2 pulse not before third edge", pll_update, 0);
    step(1);
    check(pll_update == 1'b1, "R2 pulse after third edge", pll_update, 1);
    step(1);
    check(pll_update == 1'b0, "R2 pulse one cycle", pll_update, 0);
    for (int i = 0; i < int'(Q + HANG) + 20; i++) begin
      if (!dcd_hi) lows++;
      step(1);
    end
    check(lows == 0, "R6 short burst bridged", lows, 0);
  endtask

  task automatic t_noise;
    int highs = 0;
    int ups = 0;
    for (int i = 0; i < 1000; i++) begin
      if (i % 7 == 0) rx_nrzi = ~rx_nrzi;
      step(1);
      if (pll_update) ups++;
      if (i == int'(HANG)) check(dcd_hi == 1'b1, "R6 held through hang", dcd_hi, 1);
      if (i > int'(HANG) + 30 && dcd_hi) highs++;
    end
    check(highs == 0, "R5 no detect on noise", highs, 0);
    check(ups > 50, "R2 corrections on noise", ups, 51);
  endtask

  task automatic t_locked;
    int ups = 0;
    int vlds = 0;
    int ones = 0;
    for (int i = 0; i < 640; i++) begin
      if (i % 16 == 0) rx_nrzi = ~rx_nrzi;
      step(1);
      if (i >= 64) begin
        if (pll_update) ups++;
        if (rx_bit_vld) begin
          vlds++;
          if (rx_bit) ones++;
        end
      end
    end
    check(ups == 0, "R3 no correction when locked", ups, 0);
    check(vlds == 36, "R3 one strobe per bit", vlds, 36);
    check(ones == 0, "R3 transitions decode to zero", ones, 0);
    check(dcd_hi == 1'b1, "R4 detect on locked data", dcd_hi, 1);
  endtask

  task automatic t_constant;
    int vlds = 0;
    int ones = 0;
    for (int i = 0; i < 352; i++) begin
      step(1);
      if (i >= 32 && rx_bit_vld) begin
        vlds++;
        if (rx_bit) ones++;
      end
    end
    check(vlds == 20, "R3 strobe count on steady line", vlds, 20);
    check(ones == 20, "R3 steady line decodes to one", ones, 20);
  endtask

  task automatic t_carrier;
    modem_cd = 1'b0;
    step(2);
    check(dcd_hi == 1'b1, "R7 not yet gated", dcd_hi, 1);
    step(1);
    check(dcd_hi == 1'b0, "R7 gated on third edge", dcd_hi, 0);
    check(dcd_lo_n == 1'b1, "R8 low output gated", dcd_lo_n, 1);
    cd_active_low = 1'b1;
    step(4);
    check(dcd_hi == 1'b1, "R7 active-low source active", dcd_hi, 1);
    modem_cd = 1'b1;
    step(4);
    check(dcd_hi == 1'b0, "R7 active-low source idle", dcd_hi, 0);
    check(dcd_lo_n == 1'b1, "R8 complement", dcd_lo_n, 1);
    cd_active_low = 1'b0;
    step(4);
    check(dcd_hi == 1'b1, "R7 active-high restored", dcd_hi, 1);
  endtask

  initial begin
    @(negedge clk_os);
    t_reset;
    t_saturate;
    t_update_latency;
    t_noise;
    t_locked;
    t_constant;
    t_carrier;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_os);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule